// File: doc/BRIEF.md
# Three-Lane Serial PCM Audio Receiver

This block deserialises PCM audio arriving on three data lanes. All three lanes share one bit clock and one frame clock. During each frame a lane carries two words: one for the left channel and one for the right. The block therefore delivers six channels per frame. The block is clocked directly by the serial bit clock. It captures every data bit and samples the frame clock on the rising edge, and it uses changes in the frame-clock level to find where each word begins and ends.

Three framings are supported:
- I2S framing.
- Left-justified framing.
- Right-justified framing.

Four word lengths are supported: 24, 20, 18 and 16 bits. Both the framing and the word length come from static configuration pins, which are changed only while the block is in reset. Every received word is placed at the top of a 24-bit sample, and the unused low bits are filled with zeros. The six samples update together, and a single-cycle strobe marks each new frame. Downstream filtering logic uses that strobe as its sample-rate enable.

Top module: `tri_lane_pcm_rx`

## Requirements
- R1: Lane k (k = 0..2) of `sdata` feeds output slice k of `left_smp` for its left-channel word and slice k of `right_smp` for its right-channel word.
- R2: With `fmt_sel` = 2'b00 (I2S), a low frame clock marks the left channel. The first data bit of a word, its MSB, is on the second rising edge at which the new frame-clock level is sampled. The bit on the first such edge is the LSB of the previous word.
- R3: With `fmt_sel` = 2'b01 (left-justified), a high frame clock marks the left channel. The MSB of a word is on the first rising edge at which the new frame-clock level is sampled.
- R4: With `fmt_sel` = 2'b10 (right-justified), a high frame clock marks the left channel. The word is made of the final N bits of the half-frame, with the LSB on the last edge before the frame clock changes level. Earlier bits of the half-frame have no effect.
- R5: `wlen_sel` selects N: 2'b00 gives 24, 2'b01 gives 20, 2'b10 gives 18 and 2'b11 gives 16. The N-bit word occupies sample bits [23:24-N], and bits [23-N:0] are zero.
- R6: In I2S and left-justified modes, only the first N bits of a half-frame are used. Any further bits before the next boundary have no effect on the samples.
- R7: `frame_vld` is high for exactly one cycle per frame, once the right-channel word following a left-channel word is complete. All six samples change only in the cycle where `frame_vld` is high, and otherwise hold their values.
- R8: While `rst_n` is low, all samples and `frame_vld` are zero. The half-frame in progress when reset is released is discarded, so the first strobe comes only after one complete left word and one complete right word.
- R9: With `fmt_sel` = 2'b11, the block behaves exactly as in left-justified mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; the rising edge captures data and samples the frame clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame clock; its level selects the channel and its changes mark word boundaries |
| sdata | input | 3 | One serial data bit per lane |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified, 11 left-justified |
| wlen_sel | input | 2 | Word length select: 00=24, 01=20, 10=18, 11=16 bits |
| left_smp | output | 72 | Three left-channel 24-bit samples, lane k in bits [24k+23:24k] |
| right_smp | output | 72 | Three right-channel 24-bit samples, lane k in bits [24k+23:24k] |
| frame_vld | output | 1 | One-cycle strobe when all six samples have been updated |

## Verification
The bench sweeps every framing code and every word length. It uses half-frames exactly as long as the word, one bit longer, and 32 bits long, and it fills every unused bit position with random data.

The following errors would each show up as a mismatch against the arithmetically built expected sample:
- A one-bit slip in the I2S start position would shift every word and mix in the previous word's LSB.
- A right-justified receiver that kept the leading bits instead of the trailing ones would pick up the random filler.
- A justified receiver that did not stop after N bits would shift the filler into the word.

Each run starts with a partial half-frame and ends with a trailing one. This means the following errors would change the count or order of the strobes:
- Accepting the first, partial half-frame after reset.
- Emitting a strobe on a right word that has no left word before it.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int PCM_W = 24;
  localparam int CNT_W = $clog2(PCM_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_LJ2 = 2'b11
  } pcm_fmt_e;

  // word length code -> number of bits
  function automatic int word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 24;
      2'b01:   return 20;
      2'b10:   return 18;
      default: return 16;
    endcase
  endfunction

  // move the low n bits of raw to the top of the sample, zero below
  function automatic logic [PCM_W-1:0] left_align(input logic [PCM_W-1:0] raw,
                                                  input logic [1:0] code);
    int sh;
    sh = PCM_W - word_bits(code);
    return raw << sh;
  endfunction

  // mask of the padding bits below a word of the given length
  function automatic logic [PCM_W-1:0] pad_mask(input logic [1:0] code);
    int sh;
    sh = PCM_W - word_bits(code);
    return ~({PCM_W{1'b1}} << sh);
  endfunction

endpackage

// File: rtl/pcm_frame_tracker.sv
module pcm_frame_tracker (
  input  logic bclk,
  input  logic rst_n,
  input  logic fsync,
  input  logic is_i2s,
  output logic bnd,
  output logic done_ok,
  output logic done_left
);

  logic primed;
  logic lr_q;
  logic chg;
  logic chg_d;
  logic new_left;
  logic slot_left_q;
  logic slot_ok;

  // frame clock level differs from the level seen on the previous edge
  assign chg      = primed & (fsync ^ lr_q);
  // I2S words start one bit clock after the level change
  assign bnd      = is_i2s ? chg_d : chg;
  assign new_left = is_i2s ? ~lr_q : fsync;

  assign done_ok   = bnd & slot_ok;
  assign done_left = slot_left_q;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      primed      <= 1'b0;
      lr_q        <= 1'b0;
      chg_d       <= 1'b0;
      slot_left_q <= 1'b0;
      slot_ok     <= 1'b0;
    end else begin
      primed <= 1'b1;
      lr_q   <= fsync;
      chg_d  <= chg;
      if (bnd) begin
        slot_left_q <= new_left;
        slot_ok     <= 1'b1;
      end
    end
  end

  // R8: nothing is reported as complete before a first boundary was seen
  p_no_early_done_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    done_ok |-> $past(primed));

endmodule

// File: rtl/pcm_lane_shifter.sv
module pcm_lane_shifter
  import pcm_rx_pkg::*;
(
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             sd,
  input  logic             bnd,
  input  logic             keep_all,
  input  logic [CNT_W-1:0] nbits,
  output logic [PCM_W-1:0] raw_word
);

  logic [PCM_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             take;

  // right-justified keeps shifting so the newest N bits remain;
  // the other framings freeze after N bits
  assign take     = keep_all | (cnt < nbits);
  assign raw_word = acc;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (bnd) begin
      acc <= {{(PCM_W-1){1'b0}}, sd};
      cnt <= CNT_W'(1);
    end else begin
      if (take)
        acc <= {acc[PCM_W-2:0], sd};
      if (cnt != CNT_W'(PCM_W))
        cnt <= cnt + CNT_W'(1);
    end
  end

  // R6: bit counter saturates at the sample width
  p_cnt_bound_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    cnt <= CNT_W'(PCM_W));

endmodule

// File: rtl/tri_lane_pcm_rx.sv
module tri_lane_pcm_rx
  import pcm_rx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                        bclk,
  input  logic                        rst_n,
  input  logic                        fsync,
  input  logic [LANES-1:0]            sdata,
  input  logic [1:0]                  fmt_sel,
  input  logic [1:0]                  wlen_sel,
  output logic [LANES-1:0][PCM_W-1:0] left_smp,
  output logic [LANES-1:0][PCM_W-1:0] right_smp,
  output logic                        frame_vld
);

  logic                        is_i2s;
  logic                        is_rj;
  logic [CNT_W-1:0]            nbits;
  logic                        bnd;
  logic                        done_ok;
  logic                        done_left;
  logic                        have_left;
  logic [LANES-1:0][PCM_W-1:0] raw;
  logic [LANES-1:0][PCM_W-1:0] aligned;
  logic [LANES-1:0][PCM_W-1:0] left_hold;
  logic [PCM_W-1:0]            pmask;

  assign is_i2s = (fmt_sel == FMT_I2S);
  assign is_rj  = (fmt_sel == FMT_RJ);
  assign nbits  = CNT_W'(word_bits(wlen_sel));
  assign pmask  = pad_mask(wlen_sel);

  pcm_frame_tracker u_trk (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .is_i2s    (is_i2s),
    .bnd       (bnd),
    .done_ok   (done_ok),
    .done_left (done_left)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pcm_lane_shifter u_sh (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .sd       (sdata[k]),
      .bnd      (bnd),
      .keep_all (is_rj),
      .nbits    (nbits),
      .raw_word (raw[k])
    );

    always_comb aligned[k] = left_align(raw[k], wlen_sel);

    // R5: strobed samples carry zero padding below the word
    p_pad_zero_r5: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_vld |-> (((left_smp[k] | right_smp[k]) & pmask) == '0));
  end

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      left_smp  <= '0;
      right_smp <= '0;
      left_hold <= '0;
      have_left <= 1'b0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (done_ok) begin
        if (done_left) begin
          left_hold <= aligned;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_smp  <= left_hold;
          right_smp <= aligned;
          have_left <= 1'b0;
          frame_vld <= 1'b1;
        end
      end
    end
  end

  // R7: strobe lasts a single cycle
  p_vld_pulse_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R7: samples only move together with the strobe
  p_hold_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_vld |-> ($stable(left_smp) && $stable(right_smp)));

endmodule

// File: tb/tri_lane_pcm_rx_test.sv
module tri_lane_pcm_rx_test;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fsync = 1'b0;
  logic [2:0]        sdata = '0;
  logic [1:0]        fmt_sel = '0;
  logic [1:0]        wlen_sel = '0;
  logic [2:0][23:0]  left_smp;
  logic [2:0][23:0]  right_smp;
  logic              frame_vld;

  always #10 clk = ~clk;

  tri_lane_pcm_rx uut (
    .bclk      (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .sdata     (sdata),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .frame_vld (frame_vld)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_l [0:3][0:2];
  logic [23:0] exp_r [0:3][0:2];
  logic [2:0]  ljb [0:511];
  logic        fsb [0:511];
  bit          mon_en = 1'b0;
  int          fidx = 0;
  bit          prev_vld = 1'b0;
  string       cur_tag = "";

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (frame_vld && prev_vld)
        chk("R7 strobe longer than one cycle", 24'd1, 24'd0);
      if (frame_vld) begin
        if (fidx < 4) begin
          for (int k = 0; k < 3; k++) begin
            chk({cur_tag, " R1 R5 left"}, left_smp[k], exp_l[fidx][k]);
            chk({cur_tag, " R1 R5 right"}, right_smp[k], exp_r[fidx][k]);
          end
        end
        fidx++;
      end
    end
    prev_vld = frame_vld;
  end

  task automatic run_cfg(input int f, input int w, input int slen, input int nfr);
    int n;
    bit left_lvl;
    int nslots;
    int total;
    n = (w == 0) ? 24 : (w == 1) ? 20 : (w == 2) ? 18 : 16;
    left_lvl = (f == 0) ? 1'b0 : 1'b1;
    nslots = 2 * nfr + 2;
    total = nslots * slen;
    case (f)
      0:       cur_tag = "R2";
      1:       cur_tag = "R3";
      2:       cur_tag = "R4";
      default: cur_tag = "R9";
    endcase
    if (f != 2 && slen > n) cur_tag = {cur_tag, " R6"};

    for (int s = 0; s < nslots; s++) begin
      bit real_slot;
      bit is_l;
      int fr;
      real_slot = (s > 0) && (s < nslots - 1);
      is_l = (s % 2) == 1;
      fr = (s - 1) / 2;
      for (int k = 0; k < 3; k++) begin
        logic [23:0] word;
        word = 24'($urandom) & ((24'd1 << n) - 24'd1);
        if (real_slot) begin
          if (is_l) exp_l[fr][k] = word * (24'd1 << (24 - n));
          else      exp_r[fr][k] = word * (24'd1 << (24 - n));
        end
        for (int i = 0; i < slen; i++) begin
          logic b;
          b = 1'($urandom);
          if (real_slot) begin
            if (f == 2) begin
              if (i >= slen - n) b = word[slen - 1 - i];
            end else begin
              if (i < n) b = word[n - 1 - i];
            end
          end
          ljb[s * slen + i][k] = b;
        end
      end
      for (int i = 0; i < slen; i++)
        fsb[s * slen + i] = (s == 0) ? ~left_lvl :
                            (s == nslots - 1) ? left_lvl :
                            (is_l ? left_lvl : ~left_lvl);
    end

    // reset with configuration applied
    @(negedge clk);
    rst_n = 1'b0;
    fmt_sel = 2'(f);
    wlen_sel = 2'(w);
    fsync = fsb[0];
    sdata = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R8 reset left", left_smp[k], 24'd0);
      chk("R8 reset right", right_smp[k], 24'd0);
    end
    chk("R8 reset strobe", {23'd0, frame_vld}, 24'd0);
    rst_n = 1'b1;
    fidx = 0;
    mon_en = 1'b1;

    for (int p = 0; p < total; p++) begin
      fsync = fsb[p];
      if (f == 0) sdata = (p == 0) ? 3'($urandom) : ljb[p - 1];
      else        sdata = ljb[p];
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    chk({cur_tag, " R7 R8 strobe count"}, 24'(fidx), 24'(nfr));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        int n;
        n = (w == 0) ? 24 : (w == 1) ? 20 : (w == 2) ? 18 : 16;
        run_cfg(f, w, n, 3);
        run_cfg(f, w, n + 1, 3);
        if (n != 32) run_cfg(f, w, 32, 3);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule